// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Engine

This block moves data between memory locations on behalf of software, one unit per request, by taking a single bus transfer slot (one read and one write) for each request. It has two independent channels. Each channel holds a source pointer, a destination pointer, a transfer counter, a counter reload value and a control word. The control word sets the enable, the unit size (8 or 16 bits), which side advances after each unit, and whether the channel stops or starts over when its count runs out.

Software programs a channel through a small register port and then enables it. After that, every pulse on the channel's request input, or a software trigger written through the control word, moves one unit. At most one side, source or destination, can be the advancing side; the other side stays fixed. Both sides fixed is allowed. When the counter wraps below zero, the channel raises a one-cycle interrupt pulse. In single mode the channel then disables itself. In repeat mode it reloads the counter and keeps running.

Top module: `dmac2ch`

## Requirements
- R1: After reset every register of both channels reads zero, `irq` is low and `bus_req` is low. Register offsets within a channel (`cpu_addr[2:0]`) are: 0 source, 1 destination, 2 live counter (read only), 3 reload, 4 control. `cpu_addr[3]` selects the channel. Control bits are: 0 enable, 1 16-bit unit, 2 source advances, 3 destination advances, 4 repeat, 5 software trigger (write only, reads 0).
- R2: A control write that sets both advance bits (2 and 3) is rejected as a whole, and the control word keeps its previous value.
- R3: While the channel is enabled, a write to the fixed-side pointer register is ignored. A write to the advancing-side register takes effect at any time.
- R4: A request that arrives on a disabled channel causes no bus activity.
- R5: Each transfer reads the source address and then writes the captured data to the destination address. For an 8-bit unit the upper byte of the write data is zero. `bus_wide` shows the unit size. Each phase holds its address until a cycle with `bus_gnt` high.
- R6: The first transfer after enable goes from 0 to 1 copies the advancing-side register into the internal pointer, and the reload register into the counter. Values written after enable but before that first transfer are therefore used.
- R7: After each transfer the advancing address grows by 1 for 8-bit units and by 2 for 16-bit units, wrapping within 20 bits. The fixed address never changes.
- R8: While enabled, and after the first transfer, reading the advancing-side register returns the live pointer, and offset 2 returns the live counter.
- R9: A reload value N yields N+1 transfers before the counter wraps. That last transfer gives exactly one single-cycle `irq` pulse for the channel.
- R10: In single mode the wrap clears the enable bit, and later requests are ignored.
- R11: In repeat mode the wrap reloads the counter from the reload register, and the channel stays enabled.
- R12: When both channels have a request waiting at the same time, channel 0 is served first.
- R13: Requests that arrive while a channel's transfer is in flight are merged into one more transfer.
- R14: Writing control with enable and software trigger both set starts one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Channel (bit 3) and register offset (bits 2:0) |
| cpu_wdata | input | 20 | Register write data |
| cpu_rdata | output | 20 | Register read data (combinational) |
| dreq | input | 2 | Per-channel request, one request per high cycle |
| irq | output | 2 | Per-channel counter wrap pulse |
| bus_req | output | 1 | Bus phase pending |
| bus_gnt | input | 1 | Phase completes at this edge |
| bus_we | output | 1 | 1 for write phase, 0 for read phase |
| bus_wide | output | 1 | 1 for a 16-bit unit |
| bus_addr | output | 20 | Phase address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, captured on the read handshake |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a request on each channel in one clock. The second pair is a new request that arrives while a transfer for the same channel is still in its stalled read phase. The bench drives both request lines high in the same cycle and judges the order of the logged bus reads by their distinct source addresses. It also inserts wait states with the grant responder and pulses the request line twice more during the stall. The count of logged phases must then show exactly one extra transfer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [1:0] {XF_IDLE, XF_RD, XF_WR} xf_state_e;

   localparam logic [2:0] RG_SRC = 3'd0;
   localparam logic [2:0] RG_DST = 3'd1;
   localparam logic [2:0] RG_CNT = 3'd2;
   localparam logic [2:0] RG_RLD = 3'd3;
   localparam logic [2:0] RG_CTL = 3'd4;

   localparam int CB_EN   = 0;
   localparam int CB_WIDE = 1;
   localparam int CB_SFWD = 2;
   localparam int CB_DFWD = 3;
   localparam int CB_REP  = 4;
   localparam int CB_TRIG = 5;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_reg,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [2:0]        rd_reg,
   output logic [ADDR_W-1:0] rd_data,
   input  logic              req_in,
   input  logic              grant,
   input  logic              done,
   output logic              pend,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              wide,
   output logic              irq
);
   localparam int PAD_W = ADDR_W - CNT_W;

   logic en_q, wide_q, sfwd_q, dfwd_q, rep_q, fresh_q, pend_q, irq_q;
   logic [ADDR_W-1:0] src_q, dst_q, ptr_q;
   logic [CNT_W-1:0]  cnt_q, rld_q;

   logic ctl_wr, ctl_take, at_zero, uflow;
   logic [ADDR_W-1:0] fwd_reg, fwd_now, step;

   assign ctl_wr   = wr_en && (wr_reg == RG_CTL);
   assign ctl_take = ctl_wr && !(wr_data[CB_SFWD] && wr_data[CB_DFWD]);
   assign at_zero  = (cnt_q == '0);
   assign uflow    = done && at_zero;
   assign fwd_reg  = sfwd_q ? src_q : dst_q;
   assign fwd_now  = fresh_q ? fwd_reg : ptr_q;
   assign step     = wide_q ? ADDR_W'(2) : ADDR_W'(1);

   assign src_addr = sfwd_q ? fwd_now : src_q;
   assign dst_addr = dfwd_q ? fwd_now : dst_q;
   assign wide     = wide_q;
   assign pend     = pend_q;
   assign irq      = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0; wide_q <= 1'b0; sfwd_q <= 1'b0; dfwd_q <= 1'b0;
         rep_q <= 1'b0; fresh_q <= 1'b0; pend_q <= 1'b0; irq_q <= 1'b0;
         src_q <= '0; dst_q <= '0; ptr_q <= '0; cnt_q <= '0; rld_q <= '0;
      end else begin
         irq_q <= uflow;
         if (wr_en && (wr_reg == RG_SRC) && (sfwd_q || !en_q)) src_q <= wr_data;
         if (wr_en && (wr_reg == RG_DST) && (dfwd_q || !en_q)) dst_q <= wr_data;
         if (wr_en && (wr_reg == RG_RLD)) rld_q <= wr_data[CNT_W-1:0];
         if (grant) begin
            pend_q <= 1'b0;
            if (fresh_q) begin
               ptr_q   <= fwd_reg;
               cnt_q   <= rld_q;
               fresh_q <= 1'b0;
            end
         end
         if (en_q && req_in) pend_q <= 1'b1;
         if (done) begin
            ptr_q <= ptr_q + step;
            if (at_zero && rep_q) cnt_q <= rld_q;
            else                  cnt_q <= cnt_q - CNT_W'(1);
            if (at_zero && !rep_q) begin
               en_q   <= 1'b0;
               pend_q <= 1'b0;
            end
         end
         if (ctl_take) begin
            en_q   <= wr_data[CB_EN];
            wide_q <= wr_data[CB_WIDE];
            sfwd_q <= wr_data[CB_SFWD];
            dfwd_q <= wr_data[CB_DFWD];
            rep_q  <= wr_data[CB_REP];
            if (wr_data[CB_EN] && !en_q) fresh_q <= 1'b1;
            if (!wr_data[CB_EN])         pend_q  <= 1'b0;
            else if (wr_data[CB_TRIG])   pend_q  <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (rd_reg)
         RG_SRC:  rd_data = (en_q && sfwd_q && !fresh_q) ? ptr_q : src_q;
         RG_DST:  rd_data = (en_q && dfwd_q && !fresh_q) ? ptr_q : dst_q;
         RG_CNT:  rd_data = {{PAD_W{1'b0}}, cnt_q};
         RG_RLD:  rd_data = {{PAD_W{1'b0}}, rld_q};
         RG_CTL:  rd_data = ADDR_W'({rep_q, dfwd_q, sfwd_q, wide_q, en_q});
         default: rd_data = '0;
      endcase
   end

   // R9
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10
   single_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && at_zero && !rep_q && !ctl_wr) |=> !en_q);

   // R11
   repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && at_zero && rep_q && !ctl_wr) |=> (en_q && cnt_q == $past(rld_q)));

   // R3
   fixed_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !sfwd_q && !ctl_wr) |=> $stable(src_q));
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
   parameter int NCH = 2
) (
   input  logic           idle,
   input  logic [NCH-1:0] pend,
   output logic [NCH-1:0] gnt
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < NCH; i++) begin
         if (idle && pend[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
   import dmac_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCH-1:0]            gnt_ch,
   input  logic [NCH-1:0][ADDR_W-1:0] src_a,
   input  logic [NCH-1:0][ADDR_W-1:0] dst_a,
   input  logic [NCH-1:0]            wide_a,
   output logic                      idle,
   output logic [NCH-1:0]            done,
   output logic                      bus_req,
   input  logic                      bus_gnt,
   output logic                      bus_we,
   output logic                      bus_wide,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic [DATA_W-1:0]         bus_wdata,
   input  logic [DATA_W-1:0]         bus_rdata
);
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

   xf_state_e         st;
   logic [IDX_W-1:0]  ch_q, pick;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic              wide_q;
   logic [DATA_W-1:0] data_q;

   always_comb begin
      pick = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (gnt_ch[i]) pick = IDX_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= XF_IDLE; ch_q <= '0; src_q <= '0; dst_q <= '0;
         wide_q <= 1'b0; data_q <= '0;
      end else begin
         unique case (st)
            XF_IDLE: if (|gnt_ch) begin
               ch_q   <= pick;
               src_q  <= src_a[pick];
               dst_q  <= dst_a[pick];
               wide_q <= wide_a[pick];
               st     <= XF_RD;
            end
            XF_RD: if (bus_gnt) begin
               data_q <= wide_q ? bus_rdata : {{(DATA_W-8){1'b0}}, bus_rdata[7:0]};
               st     <= XF_WR;
            end
            XF_WR: if (bus_gnt) st <= XF_IDLE;
            default: st <= XF_IDLE;
         endcase
      end
   end

   assign idle      = (st == XF_IDLE);
   assign bus_req   = (st != XF_IDLE);
   assign bus_we    = (st == XF_WR);
   assign bus_wide  = wide_q;
   assign bus_addr  = (st == XF_WR) ? dst_q : src_q;
   assign bus_wdata = data_q;

   for (genvar g = 0; g < NCH; g++) begin : g_done
      assign done[g] = (st == XF_WR) && bus_gnt && (ch_q == IDX_W'(g));
   end

   // R5
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R5
   rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we) |-> $past(bus_req && bus_gnt && !bus_we));
endmodule

// File: rtl/dmac2ch.sv
module dmac2ch #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [3:0]        cpu_addr,
   input  logic [ADDR_W-1:0] cpu_wdata,
   output logic [ADDR_W-1:0] cpu_rdata,
   input  logic [1:0]        dreq,
   output logic [1:0]        irq,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_we,
   output logic              bus_wide,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int NCH = 2;

   if (DATA_W != 16) begin : g_bad_data
      $error("dmac2ch: DATA_W must be 16");
   end
   if (CNT_W >= ADDR_W) begin : g_bad_cnt
      $error("dmac2ch: CNT_W must be narrower than ADDR_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("dmac2ch: ADDR_W too small");
   end

   logic [NCH-1:0]             pend, gnt, done, wide_a;
   logic                       idle;
   logic [NCH-1:0][ADDR_W-1:0] src_a, dst_a, rd_a;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dmac_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cpu_we && (cpu_addr[3] == 1'(g))),
         .wr_reg   (cpu_addr[2:0]),
         .wr_data  (cpu_wdata),
         .rd_reg   (cpu_addr[2:0]),
         .rd_data  (rd_a[g]),
         .req_in   (dreq[g]),
         .grant    (gnt[g]),
         .done     (done[g]),
         .pend     (pend[g]),
         .src_addr (src_a[g]),
         .dst_addr (dst_a[g]),
         .wide     (wide_a[g]),
         .irq      (irq[g])
      );
   end

   dmac_arb #(.NCH(NCH)) u_arb (
      .idle (idle),
      .pend (pend),
      .gnt  (gnt)
   );

   dmac_xfer #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_ch    (gnt),
      .src_a     (src_a),
      .dst_a     (dst_a),
      .wide_a    (wide_a),
      .idle      (idle),
      .done      (done),
      .bus_req   (bus_req),
      .bus_gnt   (bus_gnt),
      .bus_we    (bus_we),
      .bus_wide  (bus_wide),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   assign cpu_rdata = rd_a[cpu_addr[3]];

   // R12
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[1] |-> !pend[0]);

   // R12
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R4
   grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |-> !bus_req);
endmodule

// File: tb/tb_dmac2ch.sv
`timescale 1ns/1ps
module tb_dmac2ch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [3:0]  cpu_addr = '0;
   logic [19:0] cpu_wdata = '0;
   logic [19:0] cpu_rdata;
   logic [1:0]  dreq = '0;
   logic [1:0]  irq;
   logic        bus_req, bus_we, bus_wide;
   logic        bus_gnt = 1'b0;
   logic [19:0] bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;

   dmac2ch dut (.*);

   always #2 clk = ~clk;

   int nchk = 0, nerr = 0;
   int wait_n = 0, wcnt = 0, nlog = 0;
   int irq_cnt [2] = '{0, 0};
   logic        log_we   [64];
   logic        log_wide [64];
   logic [19:0] log_addr [64];
   logic [15:0] log_data [64];
   bit finished = 0;

   function automatic logic [15:0] fdat(input logic [19:0] a);
      return {a[7:0] ^ 8'hA5, a[7:0]};
   endfunction

   always @(negedge clk) begin
      if (irq[0]) irq_cnt[0]++;
      if (irq[1]) irq_cnt[1]++;
      if (!rst_n || !bus_req) begin
         bus_gnt = 1'b0; wcnt = 0;
      end else if (wcnt < wait_n) begin
         bus_gnt = 1'b0; wcnt++;
      end else begin
         bus_gnt = 1'b1; wcnt = 0;
         bus_rdata = fdat(bus_addr);
         if (nlog < 64) begin
            log_we[nlog] = bus_we; log_wide[nlog] = bus_wide;
            log_addr[nlog] = bus_addr; log_data[nlog] = bus_wdata;
         end
         nlog++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int ch, input int rg, input logic [19:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = {ch[0], rg[2:0]}; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic rd(input int ch, input int rg, output logic [19:0] v);
      @(negedge clk);
      cpu_addr = {ch[0], rg[2:0]};
      #1 v = cpu_rdata;
   endtask

   task automatic pulse(input logic [1:0] m);
      @(negedge clk); dreq = m;
      @(negedge clk); dreq = 2'b00;
   endtask

   task automatic settle();
      repeat (16) @(negedge clk);
   endtask

   typedef struct packed {
      logic        ch;
      logic        wide;
      logic        sfwd;
      logic        dfwd;
      logic [19:0] src;
      logic [19:0] dst;
      logic [3:0]  rld;
      logic [1:0]  waits;
   } vec_t;

   localparam vec_t TBL [4] = '{
      '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00010, 20'h80000, 4'd3, 2'd0},
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h00F00, 20'h00020, 4'd2, 2'd1},
      '{1'b1, 1'b0, 1'b0, 1'b0, 20'h12345, 20'h54321, 4'd1, 2'd2},
      '{1'b1, 1'b1, 1'b1, 1'b0, 20'hFFFFC, 20'h00040, 4'd2, 2'd0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nerr++; nchk++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [19:0] v;
      int base, bad;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int c = 0; c < 2; c++)
         for (int r = 0; r < 5; r++) begin
            rd(c, r, v); chk("R1 reset register", v, 0);
         end
      chk("R1 bus_req idle", bus_req, 0);
      chk("R1 irq idle", irq, 0);

      // R2 both advancing rejected
      wr(0, 4, 20'h0D); rd(0, 4, v); chk("R2 both-advance rejected", v, 0);

      // R4 disabled channel ignores requests
      nlog = 0; pulse(2'b01); settle(); chk("R4 no bus activity", nlog, 0);

      // Vector table walk: R5, R7, R9, R10
      for (int e = 0; e < 4; e++) begin
         vec_t t;
         int step;
         t = TBL[e]; step = t.wide ? 2 : 1;
         wait_n = t.waits; nlog = 0; base = irq_cnt[t.ch];
         wr(t.ch, 0, t.src); wr(t.ch, 1, t.dst); wr(t.ch, 3, 20'(t.rld));
         wr(t.ch, 4, {15'd0, t.dfwd, t.sfwd, t.wide, 1'b1});
         for (int k = 0; k <= int'(t.rld); k++) begin
            pulse(t.ch ? 2'b10 : 2'b01); settle();
         end
         chk("R9 phase count", nlog, 2 * (int'(t.rld) + 1));
         bad = 0;
         for (int k = 0; k <= int'(t.rld) && 2*k+1 < 64; k++) begin
            logic [19:0] sa, da;
            logic [15:0] ed;
            sa = t.sfwd ? t.src + 20'(k*step) : t.src;
            da = t.dfwd ? t.dst + 20'(k*step) : t.dst;
            ed = t.wide ? fdat(sa) : {8'h00, fdat(sa)[7:0]};
            if (log_we[2*k] !== 1'b0 || log_addr[2*k] !== sa) bad++;
            if (log_we[2*k+1] !== 1'b1 || log_addr[2*k+1] !== da) bad++;
            if (log_data[2*k+1] !== ed || log_wide[2*k+1] !== t.wide) bad++;
         end
         chk("R5 R7 address and data sequence", bad, 0);
         chk("R9 one irq pulse", irq_cnt[t.ch] - base, 1);
         rd(t.ch, 4, v); chk("R10 enable cleared", v[0], 0);
         nlog = 0; pulse(t.ch ? 2'b10 : 2'b01); settle();
         chk("R10 later request ignored", nlog, 0);
      end
      wait_n = 0;

      // R6 first-transfer load, R3 fixed lock
      wr(0, 0, 20'h100); wr(0, 1, 20'h200); wr(0, 3, 20'd5); wr(0, 4, 20'h05);
      wr(0, 0, 20'h300); wr(0, 3, 20'd1); wr(0, 1, 20'h999);
      rd(0, 1, v); chk("R3 fixed register locked", v, 20'h200);
      nlog = 0; base = irq_cnt[0];
      pulse(2'b01); settle(); pulse(2'b01); settle();
      chk("R6 first read from new pointer", log_addr[0], 20'h300);
      chk("R6 second read advanced", log_addr[2], 20'h301);
      chk("R6 counter from new reload", irq_cnt[0] - base, 1);

      // R8 live pointer/counter, R3 advancing register writable
      wr(0, 0, 20'h40); wr(0, 1, 20'h500); wr(0, 3, 20'd5); wr(0, 4, 20'h0B);
      pulse(2'b01); settle(); pulse(2'b01); settle();
      rd(0, 1, v); chk("R8 live pointer", v, 20'h504);
      rd(0, 2, v); chk("R8 live counter", v, 20'd3);
      wr(0, 1, 20'h777); wr(0, 4, 20'h0A);
      rd(0, 1, v); chk("R3 advancing register written while enabled", v, 20'h777);

      // R11 repeat mode
      wr(1, 0, 20'h60); wr(1, 1, 20'h70); wr(1, 3, 20'd1); wr(1, 4, 20'h15);
      nlog = 0; base = irq_cnt[1];
      for (int k = 0; k < 5; k++) begin pulse(2'b10); settle(); end
      chk("R11 five transfers", nlog, 10);
      chk("R11 two irq pulses", irq_cnt[1] - base, 2);
      rd(1, 4, v); chk("R11 still enabled", v, 20'h15);
      rd(1, 2, v); chk("R11 counter after reload", v, 0);
      rd(1, 0, v); chk("R11 pointer kept running", v, 20'h65);
      wr(1, 4, 20'h0);

      // R12 priority
      wr(0, 0, 20'hA00); wr(0, 1, 20'hB00); wr(0, 3, 20'd9); wr(0, 4, 20'h01);
      wr(1, 0, 20'hC00); wr(1, 1, 20'hD00); wr(1, 3, 20'd9); wr(1, 4, 20'h01);
      nlog = 0; pulse(2'b11); settle();
      chk("R12 two transfers", nlog, 4);
      chk("R12 channel 0 first", log_addr[0], 20'hA00);
      chk("R12 channel 1 second", log_addr[2], 20'hC00);

      // R13 merged requests during stall
      wait_n = 3; nlog = 0;
      pulse(2'b01); pulse(2'b01); pulse(2'b01); settle(); settle();
      chk("R13 merged to one extra transfer", nlog, 4);
      wait_n = 0;
      wr(0, 4, 20'h0); wr(1, 4, 20'h0);

      // R14 software trigger
      wr(1, 0, 20'hE0); wr(1, 1, 20'hF0); wr(1, 3, 20'd3);
      nlog = 0; wr(1, 4, 20'h21); settle();
      chk("R14 one triggered transfer", nlog, 2);
      chk("R14 source address", log_addr[0], 20'hE0);
      wr(1, 4, 20'h0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule